// File: doc/BRIEF.md
# Filtered Quadrature Encoder Counter

This block tracks the position of a rotary or linear encoder. Four inputs (channel A, channel B, an index pulse and an index-mask qualifier) are brought into the system clock domain by a two-flop synchronizer. Each input then passes through a glitch filter whose acceptance length is chosen at run time. The cleaned signals feed a decoder. In quadrature mode the decoder counts every edge of both channels. In step/direction mode it counts rising edges of A, and B sets the direction.

Two signed counters are maintained. The working count can be zeroed by a level-sensitive clear input. It can also be zeroed on an index edge that passes polarity and mask qualification, but only while the index latch is armed. The raw count only follows motion, and only the block reset clears it. The index latch is armed and disarmed by single-cycle pulses, and it clears itself when it fires. Velocity estimation and unit scaling are done elsewhere.

Top module: `qenc_counter`

## Requirements
- R1: After rst_n is released, count, raw_count and idx_armed are all zero.
- R2: With cfg_stepdir=0, every legal one-bit change of the filtered {A,B} pair changes the count by one. The sequence 00→10→11→01→00 (A leading B) counts up and the reverse sequence counts down.
- R3: With cfg_stepdir=0, a change in which A and B both flip between two filtered samples leaves both counts unchanged.
- R4: With cfg_stepdir=1, each rising edge of filtered A counts up when B is low and down when B is high; a falling edge of A does not count.
- R5: With cfg_filt_en=1, an input level must be seen on 15 consecutive clock samples before it is accepted; a 14-cycle pulse is discarded.
- R6: With cfg_filt_en=0, 3 consecutive samples are enough; a 2-cycle pulse is discarded.
- R7: cfg_idx_rise=1 makes the rising edge of the filtered index the index event; cfg_idx_rise=0 makes it the falling edge.
- R8: With cfg_mask_en=1, an index event is qualified only while the filtered mask input is high (cfg_mask_low=0) or low (cfg_mask_low=1); with cfg_mask_en=0 every index event is qualified.
- R9: A one-cycle pulse on arm_set sets idx_armed and a pulse on arm_clr clears it. A qualified index event while armed zeroes count and clears idx_armed on the same clock edge. A qualified index event while disarmed changes nothing.
- R10: While cnt_zero is high, count is held at zero; after it falls, counting resumes from zero.
- R11: raw_count follows every counted step and is never altered by index events or cnt_zero.
- R12: Between consecutive clocks, count either moves by at most one or becomes zero, and raw_count moves by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the sample clock |
| rst_n | input | 1 | Active-low reset, clears every register |
| enc_a | input | 1 | Channel A, or step in step/direction mode |
| enc_b | input | 1 | Channel B, or direction in step/direction mode |
| enc_idx | input | 1 | Index pulse |
| enc_msk | input | 1 | Index qualifier |
| cfg_stepdir | input | 1 | 0 quadrature, 1 step/direction |
| cfg_filt_en | input | 1 | 1 selects the long filter, 0 the short one |
| cfg_idx_rise | input | 1 | 1 rising index edge, 0 falling |
| cfg_mask_en | input | 1 | Require the qualifier for index events |
| cfg_mask_low | input | 1 | Qualifier is active low |
| arm_set | input | 1 | Pulse to arm the index latch |
| arm_clr | input | 1 | Pulse to disarm the index latch |
| cnt_zero | input | 1 | Level: hold count at zero |
| count | output | CNT_W | Working signed count |
| raw_count | output | CNT_W | Motion-only signed count |
| idx_armed | output | 1 | Index latch state |

## Verification
The checker watches on every cycle that the count moves by one step at most or drops to zero. It also checks that the raw count moves by one step at most, that a held clear input forces a zero count, and that any disarm not caused by arm_clr coincides with a zero count. It cannot tell whether a given step went in the right direction, whether a pulse had the length the filter needs, or whether the polarity and mask choices were honoured. The bench covers those with decode sequences, pulses just below and at each filter threshold, and index edges under each polarity and mask setting.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   localparam int NUM_IN = 4;
   localparam int IN_A   = 0;
   localparam int IN_B   = 1;
   localparam int IN_IDX = 2;
   localparam int IN_MSK = 3;
endpackage

// File: rtl/qenc_filter.sv
// Synchronizer plus saturating-count glitch filter, one lane per input.
module qenc_filter #(
   parameter int LANES      = 4,
   parameter int FILT_LONG  = 15,
   parameter int FILT_SHORT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             long_en,
   input  logic [LANES-1:0] pins,
   output logic [LANES-1:0] clean
);
   localparam int CW = $clog2(FILT_LONG + 1);
   localparam logic [CW-1:0] LIM_L = CW'(FILT_LONG - 1);
   localparam logic [CW-1:0] LIM_S = CW'(FILT_SHORT - 1);

   logic [CW-1:0] lim;
   assign lim = long_en ? LIM_L : LIM_S;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic          s1, s2, q;
      logic [CW-1:0] run;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            q   <= 1'b0;
            run <= '0;
         end else begin
            s1 <= pins[g];
            s2 <= s1;
            if (s2 == q) begin
               run <= '0;
            end else if (run >= lim) begin
               q   <= s2;
               run <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end
      end
      assign clean[g] = q;
   end
endmodule

// File: rtl/qenc_decode.sv
// Turns filtered A/B into up/down count strobes.
module qenc_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic stepdir,
   input  logic a,
   input  logic b,
   output logic up,
   output logic dn
);
   logic pa, pb;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa <= 1'b0;
         pb <= 1'b0;
      end else begin
         pa <= a;
         pb <= b;
      end
   end

   always_comb begin
      up = 1'b0;
      dn = 1'b0;
      if (stepdir) begin
         up = a & ~pa & ~b;
         dn = a & ~pa & b;
      end else begin
         unique case ({pa, pb, a, b})
            4'b0010, 4'b1011, 4'b1101, 4'b0100: up = 1'b1;
            4'b0001, 4'b0111, 4'b1110, 4'b1000: dn = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/qenc_index.sv
// Index edge selection and mask qualification.
module qenc_index (
   input  logic clk,
   input  logic rst_n,
   input  logic idx,
   input  logic msk,
   input  logic rise_sel,
   input  logic mask_en,
   input  logic mask_low,
   output logic event_q
);
   logic pidx, edge_hit, mask_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) pidx <= 1'b0;
      else        pidx <= idx;
   end
   assign edge_hit = rise_sel ? (idx & ~pidx) : (~idx & pidx);
   assign mask_ok  = ~mask_en | (msk ^ mask_low);
   assign event_q  = edge_hit & mask_ok;
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
   parameter int CNT_W      = 32,
   parameter int FILT_LONG  = 15,
   parameter int FILT_SHORT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             enc_idx,
   input  logic             enc_msk,
   input  logic             cfg_stepdir,
   input  logic             cfg_filt_en,
   input  logic             cfg_idx_rise,
   input  logic             cfg_mask_en,
   input  logic             cfg_mask_low,
   input  logic             arm_set,
   input  logic             arm_clr,
   input  logic             cnt_zero,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] raw_count,
   output logic             idx_armed
);
   import qenc_pkg::*;

   if (CNT_W < 2) begin : g_bad_w
      $error("qenc_counter: CNT_W must be at least 2");
   end
   if (FILT_SHORT < 1 || FILT_LONG < FILT_SHORT) begin : g_bad_f
      $error("qenc_counter: need 1 <= FILT_SHORT <= FILT_LONG");
   end

   logic [NUM_IN-1:0] pins, clean;
   logic              up, dn, idx_ev;
   logic [CNT_W-1:0]  delta;

   assign pins[IN_A]   = enc_a;
   assign pins[IN_B]   = enc_b;
   assign pins[IN_IDX] = enc_idx;
   assign pins[IN_MSK] = enc_msk;

   qenc_filter #(.LANES(NUM_IN), .FILT_LONG(FILT_LONG), .FILT_SHORT(FILT_SHORT)) u_filt (
      .clk(clk), .rst_n(rst_n), .long_en(cfg_filt_en), .pins(pins), .clean(clean));

   qenc_decode u_dec (
      .clk(clk), .rst_n(rst_n), .stepdir(cfg_stepdir),
      .a(clean[IN_A]), .b(clean[IN_B]), .up(up), .dn(dn));

   qenc_index u_idx (
      .clk(clk), .rst_n(rst_n), .idx(clean[IN_IDX]), .msk(clean[IN_MSK]),
      .rise_sel(cfg_idx_rise), .mask_en(cfg_mask_en), .mask_low(cfg_mask_low),
      .event_q(idx_ev));

   assign delta = up ? CNT_W'(1) : (dn ? {CNT_W{1'b1}} : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count     <= '0;
         raw_count <= '0;
         idx_armed <= 1'b0;
      end else begin
         raw_count <= raw_count + delta;
         if (cnt_zero || (idx_armed && idx_ev)) count <= '0;
         else                                   count <= count + delta;
         if (idx_armed && idx_ev) idx_armed <= 1'b0;
         else if (arm_clr)        idx_armed <= 1'b0;
         else if (arm_set)        idx_armed <= 1'b1;
      end
   end
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_clr,
   input logic             cnt_zero,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] raw_count,
   input logic             idx_armed
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   a_r10_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_zero |=> count == '0);

   a_r9_disarm_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(idx_armed) && !$past(arm_clr)) |-> count == '0);

   a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (count == $past(count)) || (count == $past(count) + ONE) ||
      (count == $past(count) - ONE) || (count == '0));

   a_r11_raw_step: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_count == $past(raw_count)) || (raw_count == $past(raw_count) + ONE) ||
      (raw_count == $past(raw_count) - ONE));
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .arm_clr(arm_clr), .cnt_zero(cnt_zero),
   .count(count), .raw_count(raw_count), .idx_armed(idx_armed));

// File: tb/qenc_counter_test.sv
module qenc_counter_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enc_a = 0, enc_b = 0, enc_idx = 0, enc_msk = 0;
   logic cfg_stepdir = 0, cfg_filt_en = 0, cfg_idx_rise = 1, cfg_mask_en = 0, cfg_mask_low = 0;
   logic arm_set = 0, arm_clr = 0, cnt_zero = 0;
   logic [31:0] count, raw_count;
   logic idx_armed;
   int n_chk = 0, n_fail = 0;
   int raw_ref;

   always #2 clk = ~clk;

   qenc_counter uut (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
      .enc_msk(enc_msk), .cfg_stepdir(cfg_stepdir), .cfg_filt_en(cfg_filt_en),
      .cfg_idx_rise(cfg_idx_rise), .cfg_mask_en(cfg_mask_en), .cfg_mask_low(cfg_mask_low),
      .arm_set(arm_set), .arm_clr(arm_clr), .cnt_zero(cnt_zero),
      .count(count), .raw_count(raw_count), .idx_armed(idx_armed));

   // {A, B, expected signed count} ; R2 legal steps, R3 double flips
   localparam logic [9:0] VEC [11] = '{
      {2'b10, 8'sd1}, {2'b11, 8'sd2}, {2'b01, 8'sd3}, {2'b00, 8'sd4},
      {2'b01, 8'sd3}, {2'b11, 8'sd2}, {2'b00, 8'sd2}, {2'b10, 8'sd3},
      {2'b01, 8'sd3}, {2'b00, 8'sd4}, {2'b10, 8'sd5}};

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic settle();
      cyc(24);
   endtask

   task automatic step_a();
      enc_a = 1'b1; settle();
      enc_a = 1'b0; settle();
   endtask

   task automatic pulse_a(int len);
      enc_a = 1'b1; cyc(len);
      enc_a = 1'b0; settle();
   endtask

   task automatic arm();
      arm_set = 1'b1; cyc(1); arm_set = 1'b0; cyc(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      cyc(5);
      chk("R1 count", int'(count), 0);
      chk("R1 raw", int'(raw_count), 0);
      chk("R1 armed", int'(idx_armed), 0);
      rst_n = 1'b1;
      cyc(2);

      foreach (VEC[i]) begin
         enc_a = VEC[i][9];
         enc_b = VEC[i][8];
         settle();
         chk("R2/R3 quad count", int'($signed(count)), int'($signed(VEC[i][7:0])));
      end
      chk("R2 raw matches", int'($signed(raw_count)), 5);

      // step/dir: A low, B low
      enc_a = 0; enc_b = 0; settle();          // 10->00 is down: count 4
      cfg_stepdir = 1'b1; cyc(2);
      enc_a = 1'b1; settle();
      chk("R4 rising up", int'(count), 5);
      enc_a = 1'b0; settle();
      chk("R4 falling no count", int'(count), 5);
      step_a(); step_a();
      chk("R4 up steps", int'(count), 7);
      enc_b = 1'b1; settle();
      step_a(); step_a();
      chk("R4 down steps", int'(count), 5);
      enc_b = 1'b0; settle();

      pulse_a(2);
      chk("R6 short filter 2 rejected", int'(count), 5);
      pulse_a(3);
      chk("R6 short filter 3 accepted", int'(count), 6);
      cfg_filt_en = 1'b1; cyc(2);
      pulse_a(14);
      chk("R5 long filter 14 rejected", int'(count), 6);
      pulse_a(15);
      chk("R5 long filter 15 accepted", int'(count), 7);
      cfg_filt_en = 1'b0; cyc(2);

      raw_ref = int'(raw_count);
      cnt_zero = 1'b1; cyc(2);
      chk("R10 zero hold", int'(count), 0);
      step_a(); step_a();
      chk("R10 held through steps", int'(count), 0);
      chk("R11 raw during clear", int'(raw_count), raw_ref + 2);
      cnt_zero = 1'b0; cyc(2);
      step_a();
      chk("R10 resume", int'(count), 1);
      raw_ref = raw_ref + 3;

      enc_idx = 1'b1; settle(); enc_idx = 1'b0; settle();
      chk("R9 unarmed index ignored", int'(count), 1);
      arm();
      chk("R9 armed", int'(idx_armed), 1);
      enc_idx = 1'b1; settle();
      chk("R7 rising index zeroes", int'(count), 0);
      chk("R9 auto disarm", int'(idx_armed), 0);
      chk("R11 raw untouched by index", int'(raw_count), raw_ref);
      enc_idx = 1'b0; settle();
      step_a();
      cfg_idx_rise = 1'b0; cyc(2);
      arm();
      enc_idx = 1'b1; settle();
      chk("R7 rising ignored in falling mode", int'(count), 1);
      chk("R7 still armed", int'(idx_armed), 1);
      enc_idx = 1'b0; settle();
      chk("R7 falling index zeroes", int'(count), 0);
      step_a();
      arm();
      arm_clr = 1'b1; cyc(1); arm_clr = 1'b0; cyc(1);
      chk("R9 arm_clr disarms", int'(idx_armed), 0);

      cfg_idx_rise = 1'b1; cfg_mask_en = 1'b1; cfg_mask_low = 1'b0; enc_msk = 1'b0;
      settle();
      arm();
      enc_idx = 1'b1; settle(); enc_idx = 1'b0; settle();
      chk("R8 mask low blocks", int'(count), 1);
      enc_msk = 1'b1; settle();
      enc_idx = 1'b1; settle();
      chk("R8 mask high passes", int'(count), 0);
      enc_idx = 1'b0; settle();
      step_a();
      cfg_mask_low = 1'b1; cyc(2);
      arm();
      enc_idx = 1'b1; settle(); enc_idx = 1'b0; settle();
      chk("R8 inverted mask blocks", int'(count), 1);
      chk("R8 still armed", int'(idx_armed), 1);
      enc_msk = 1'b0; settle();
      enc_idx = 1'b1; settle();
      chk("R8 inverted mask passes", int'(count), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule